// File: doc/BRIEF.md
# Eight-bit ALU with Condition Code Register

This block is the arithmetic and logic stage of an 8-bit accumulator machine. Each enabled cycle it takes an operation code, the accumulator, a second operand, a 16-bit value and the current condition flags. It computes a new 8-bit result and a new set of five flags, and it registers both. The flags are overflow (V), half-carry (H), negative (N), zero (Z) and carry/borrow (C). The surrounding core feeds the registered flags back as `flags_in` for the next operation. Instruction decode, branching and memory access stay outside the block.

The operations are as follows:
- Binary and decimal arithmetic: add with or without carry, subtract with or without borrow, and a decimal-adjust step that turns a preceding binary add into packed BCD.
- Bitwise AND, OR and XOR.
- Single-bit shifts and rotates through carry.
- Flag-only updates for moving an 8-bit or 16-bit value.

The flag vector is packed as {V,H,N,Z,C}, with V in bit 4 and C in bit 0.

Top module: `alu8_ccr`

## Requirements
- R1: While `rst_n` is low, `result_q` reads 0x00 and `flags_q` reads 5'b00000. The bit order of `flags_q` and `flags_in` is V=bit4, H=bit3, N=bit2, Z=bit1, C=bit0.
- R2: In a cycle with `en` low, `result_q` and `flags_q` keep their values whatever the other inputs do. With `en` high, they take the new values at that rising edge.
- R3: Op 0 (add) and op 1 (add plus C from `flags_in`) give acc+opnd(+C) mod 256. C is set on a carry out of bit 7. H is set on a carry from bit 3 into bit 4. V is set when both inputs share a sign that the result does not have.
- R4: Op 2 (subtract) and op 3 (subtract minus C) give acc−opnd(−C) mod 256. C is set when a borrow is needed. V is set when the inputs differ in sign and the result's sign differs from acc. H is left as it is in `flags_in`.
- R5: Op 4 (AND), op 5 (OR) and op 6 (XOR) give the bitwise result. They clear V and leave C and H as they are in `flags_in`.
- R6: The shift and rotate ops take C from the bit that leaves the byte. Op 7 shifts left with 0 fill. Op 8 shifts right with 0 fill. Op 9 rotates left through C. Op 10 rotates right through C. V becomes N xor the new C, and H is unchanged.
- R7: Op 11 (decimal adjust) works on acc with H and C from `flags_in`. It adds 0x06 when H=1 or the low nibble exceeds 9. It then adds 0x60 when C=1, or when the intermediate sum carried past bit 7, or when its high nibble exceeds 9. The new C is set if it was set or if 0x60 was added. V and H are unchanged.
- R8: For ops 0 to 12, N equals bit 7 of the new result and Z is set exactly when the new result is 0x00.
- R9: Op 12 (8-bit move) puts `opnd` on the result. It sets N and Z from that value, clears V, and keeps C and H.
- R10: Op 13 (16-bit move) puts `wide[7:0]` on the result. N takes `wide[15]` and Z is set only when all 16 bits are zero. V is cleared, and C and H are kept.
- R11: Ops 14 and 15 register `acc` as the result and copy `flags_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Capture enable for result and flags |
| op | input | 4 | Operation code |
| acc | input | 8 | Accumulator operand |
| opnd | input | 8 | Second operand / 8-bit move value |
| wide | input | 16 | Value for 16-bit move flag update |
| flags_in | input | 5 | Current flags {V,H,N,Z,C} |
| result_q | output | 8 | Registered result |
| flags_q | output | 5 | Registered flags {V,H,N,Z,C} |

## Verification
The hardest case to reach is a decimal adjust whose correction comes from the stored half-carry or carry rather than from the nibble values. Examples are a low digit that looks valid while H is set, and a high digit that looks valid while C is set. The bench reaches these states in two steps. It first runs a binary add of chosen BCD operands, then feeds the registered result and flags back as `acc` and `flags_in` for the adjust step. This makes H and C genuine products of the adder. The bench also drives a 0x99+0x01 case, in which both nibble corrections cascade and wrap the result to zero.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW = 8;
    localparam int WW = 16;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_SHL  = 4'd7,
        OP_SHR  = 4'd8,
        OP_ROL  = 4'd9,
        OP_ROR  = 4'd10,
        OP_DADJ = 4'd11,
        OP_MV8  = 4'd12,
        OP_MV16 = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic v;
        logic h;
        logic n;
        logic z;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic [DW-1:0] res;
        ccr_t          ccr;
    } alu_state_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         half,
    output logic         ovf
);
    localparam int HB = W / 2;

    logic [W:0]  wide_sum;
    logic [HB:0] low_sum;

    always_comb begin
        if (sub) begin
            wide_sum = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        end else begin
            wide_sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        end
        low_sum = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]} + {{HB{1'b0}}, cin};
        sum  = wide_sum[W-1:0];
        cout = wide_sum[W];
        half = low_sum[HB];
        if (sub) begin
            ovf = (a[W-1] & ~b[W-1] & ~sum[W-1]) | (~a[W-1] & b[W-1] & sum[W-1]);
        end else begin
            ovf = (a[W-1] & b[W-1] & ~sum[W-1]) | (~a[W-1] & ~b[W-1] & sum[W-1]);
        end
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  logic         right,
    input  logic         rotate,
    output logic [W-1:0] r,
    output logic         cout
);
    logic fill;

    always_comb begin
        fill = rotate ? cin : 1'b0;
        if (right) begin
            r    = {fill, a[W-1:1]};
            cout = a[0];
        end else begin
            r    = {a[W-2:0], fill};
            cout = a[W-1];
        end
    end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj (
    input  logic [7:0] a,
    input  logic       h_in,
    input  logic       c_in,
    output logic [7:0] r,
    output logic       c_out
);
    logic       lo_fix;
    logic       hi_fix;
    logic [8:0] mid;

    always_comb begin
        lo_fix = h_in | (a[3:0] > 4'd9);
        mid    = {1'b0, a} + (lo_fix ? 9'h006 : 9'h000);
        hi_fix = c_in | mid[8] | (mid[7:4] > 4'd9);
        r      = mid[7:0] + (hi_fix ? 8'h60 : 8'h00);
        c_out  = c_in | hi_fix;
    end
endmodule

// File: rtl/alu8_ccr.sv
module alu8_ccr
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MOVE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    input  logic [MOVE_W-1:0] wide,
    input  logic [4:0]        flags_in,
    output logic [DATA_W-1:0] result_q,
    output logic [4:0]        flags_q
);
    localparam int MSB = DATA_W - 1;

    ccr_t       cin_s;
    alu_state_t st_d, st_q;

    logic [DATA_W-1:0] as_sum;
    logic              as_cout, as_half, as_ovf;
    logic              as_sub, as_cin;
    logic [DATA_W-1:0] sh_r;
    logic              sh_cout;
    logic [DATA_W-1:0] da_r;
    logic              da_cout;

    assign cin_s  = ccr_t'(flags_in);
    assign as_sub = (op == OP_SUB) || (op == OP_SBC);
    assign as_cin = ((op == OP_ADC) || (op == OP_SBC)) ? cin_s.c : 1'b0;

    alu8_addsub #(.W(DATA_W)) u_addsub (
        .a(acc), .b(opnd), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .cout(as_cout), .half(as_half), .ovf(as_ovf)
    );

    alu8_shift #(.W(DATA_W)) u_shift (
        .a(acc), .cin(cin_s.c),
        .right((op == OP_SHR) || (op == OP_ROR)),
        .rotate((op == OP_ROL) || (op == OP_ROR)),
        .r(sh_r), .cout(sh_cout)
    );

    alu8_decadj u_decadj (
        .a(acc[7:0]), .h_in(cin_s.h), .c_in(cin_s.c),
        .r(da_r), .c_out(da_cout)
    );

    always_comb begin
        logic nz8;
        st_d.res = acc;
        st_d.ccr = cin_s;
        nz8      = 1'b1;
        unique case (op)
            OP_ADD, OP_ADC: begin
                st_d.res   = as_sum;
                st_d.ccr.c = as_cout;
                st_d.ccr.h = as_half;
                st_d.ccr.v = as_ovf;
            end
            OP_SUB, OP_SBC: begin
                st_d.res   = as_sum;
                st_d.ccr.c = as_cout;
                st_d.ccr.v = as_ovf;
            end
            OP_AND: begin
                st_d.res   = acc & opnd;
                st_d.ccr.v = 1'b0;
            end
            OP_OR: begin
                st_d.res   = acc | opnd;
                st_d.ccr.v = 1'b0;
            end
            OP_XOR: begin
                st_d.res   = acc ^ opnd;
                st_d.ccr.v = 1'b0;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                st_d.res   = sh_r;
                st_d.ccr.c = sh_cout;
                st_d.ccr.v = sh_r[MSB] ^ sh_cout;
            end
            OP_DADJ: begin
                st_d.res   = da_r;
                st_d.ccr.c = da_cout;
            end
            OP_MV8: begin
                st_d.res   = opnd;
                st_d.ccr.v = 1'b0;
            end
            OP_MV16: begin
                st_d.res   = wide[DATA_W-1:0];
                st_d.ccr.v = 1'b0;
                st_d.ccr.n = wide[MOVE_W-1];
                st_d.ccr.z = (wide == '0);
                nz8        = 1'b0;
            end
            default: begin
                nz8 = 1'b0;
            end
        endcase
        if (nz8) begin
            st_d.ccr.n = st_d.res[MSB];
            st_d.ccr.z = (st_d.res == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (en) begin
            st_q <= st_d;
        end
    end

    assign result_q = st_q.res;
    assign flags_q  = st_q.ccr;
endmodule

// File: rtl/alu8_ccr_chk.sv
module alu8_ccr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic [3:0]  op,
    input logic [7:0]  acc,
    input logic [7:0]  opnd,
    input logic [15:0] wide,
    input logic [4:0]  flags_in,
    input logic [7:0]  result_q,
    input logic [4:0]  flags_q
);
    // R2: disabled cycles leave the registers untouched
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(result_q) && $stable(flags_q)));

    // R8: N and Z agree with the registered byte
    a_r8_nz_match: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op <= 4'd12) |=> (flags_q[2] == result_q[7]) && (flags_q[1] == (result_q == 8'h00)));

    // R5: logic ops clear V and keep C and H
    a_r5_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op >= 4'd4 && op <= 4'd6) |=>
            (!flags_q[4] && flags_q[0] == $past(flags_in[0]) && flags_q[3] == $past(flags_in[3])));

    // R4: subtraction leaves H alone
    a_r4_sub_keeps_h: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (op == 4'd2 || op == 4'd3)) |=> (flags_q[3] == $past(flags_in[3])));

    // R10: 16-bit move takes N from the top bit and clears V
    a_r10_wide_n: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 4'd13) |=> (flags_q[2] == $past(wide[15]) && !flags_q[4]));

    // R11: reserved codes pass accumulator and flags through
    a_r11_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op >= 4'd14) |=> (result_q == $past(acc) && flags_q == $past(flags_in)));

    // R7: decimal adjust never clears a set carry
    a_r7_carry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 4'd11 && flags_in[0]) |=> flags_q[0]);
endmodule

bind alu8_ccr alu8_ccr_chk u_chk (.*);

// File: tb/tb_alu8_ccr.sv
module tb_alu8_ccr;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [3:0]  op = '0;
    logic [7:0]  acc = '0;
    logic [7:0]  opnd = '0;
    logic [15:0] wide = '0;
    logic [4:0]  flags_in = '0;
    logic [7:0]  result_q;
    logic [4:0]  flags_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_ccr dut (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op), .acc(acc), .opnd(opnd),
        .wide(wide), .flags_in(flags_in), .result_q(result_q), .flags_q(flags_q)
    );

    task automatic check(input string req, input logic [7:0] er, input logic [4:0] ef);
        n_chk++;
        if (result_q !== er || flags_q !== ef) begin
            n_bad++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                     req, result_q, flags_q, er, ef);
        end
    endtask

    task automatic run_op(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                          input logic [15:0] w, input logic [4:0] f);
        @(negedge clk);
        op = o; acc = a; opnd = b; wide = w; flags_in = f; en = 1'b1;
        @(negedge clk);
        en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset", 8'h00, 5'b00000);
        rst_n = 1'b1;
    endtask

    task automatic t_add();
        run_op(4'd0, 8'h7F, 8'h01, 16'h0, 5'b00000); check("R3 add overflow", 8'h80, 5'b11100);
        run_op(4'd0, 8'hFF, 8'h01, 16'h0, 5'b00000); check("R3 add carry wrap", 8'h00, 5'b01011);
        run_op(4'd1, 8'h10, 8'h20, 16'h0, 5'b00001); check("R3 adc carry in", 8'h31, 5'b00000);
    endtask

    task automatic t_sub();
        run_op(4'd2, 8'h00, 8'h01, 16'h0, 5'b01000); check("R4 sub borrow", 8'hFF, 5'b01101);
        run_op(4'd2, 8'h80, 8'h01, 16'h0, 5'b00000); check("R4 sub overflow", 8'h7F, 5'b10000);
        run_op(4'd3, 8'h05, 8'h05, 16'h0, 5'b00001); check("R4 sbc borrow in", 8'hFF, 5'b00101);
        run_op(4'd2, 8'h05, 8'h05, 16'h0, 5'b00000); check("R8 sub zero", 8'h00, 5'b00010);
    endtask

    task automatic t_logic();
        run_op(4'd4, 8'hF0, 8'h0F, 16'h0, 5'b11001); check("R5 and keeps C H", 8'h00, 5'b01011);
        run_op(4'd5, 8'h80, 8'h01, 16'h0, 5'b00000); check("R5 or negative", 8'h81, 5'b00100);
        run_op(4'd6, 8'hAA, 8'hFF, 16'h0, 5'b10000); check("R5 xor clears V", 8'h55, 5'b00000);
    endtask

    task automatic t_shift();
        run_op(4'd7,  8'h81, 8'h00, 16'h0, 5'b00000); check("R6 shl", 8'h02, 5'b10001);
        run_op(4'd8,  8'h01, 8'h00, 16'h0, 5'b00000); check("R6 shr", 8'h00, 5'b10011);
        run_op(4'd9,  8'h80, 8'h00, 16'h0, 5'b00001); check("R6 rol", 8'h01, 5'b10001);
        run_op(4'd10, 8'h02, 8'h00, 16'h0, 5'b00001); check("R6 ror", 8'h81, 5'b10100);
        run_op(4'd10, 8'h01, 8'h00, 16'h0, 5'b01000); check("R6 ror keeps H", 8'h00, 5'b11011);
    endtask

    task automatic t_daa();
        run_op(4'd0, 8'h19, 8'h28, 16'h0, 5'b00000); check("R3 bcd add half", 8'h41, 5'b01000);
        run_op(4'd11, result_q, 8'h00, 16'h0, flags_q); check("R7 adjust by H", 8'h47, 5'b01000);
        run_op(4'd0, 8'h99, 8'h01, 16'h0, 5'b00000); check("R3 bcd add 99+1", 8'h9A, 5'b00100);
        run_op(4'd11, result_q, 8'h00, 16'h0, flags_q); check("R7 cascade wrap", 8'h00, 5'b00011);
        run_op(4'd0, 8'h90, 8'h90, 16'h0, 5'b00000); check("R3 bcd add 90+90", 8'h20, 5'b10001);
        run_op(4'd11, result_q, 8'h00, 16'h0, flags_q); check("R7 adjust by C", 8'h80, 5'b10101);
    endtask

    task automatic t_move();
        run_op(4'd12, 8'h33, 8'h00, 16'h0, 5'b11001); check("R9 move8 zero", 8'h00, 5'b01011);
        run_op(4'd12, 8'h00, 8'h80, 16'h0, 5'b00000); check("R9 move8 neg", 8'h80, 5'b00100);
        run_op(4'd13, 8'h00, 8'h00, 16'h8000, 5'b01001); check("R10 move16 neg", 8'h00, 5'b01101);
        run_op(4'd13, 8'h00, 8'h00, 16'h0000, 5'b10000); check("R10 move16 zero", 8'h00, 5'b00010);
        run_op(4'd13, 8'h00, 8'h00, 16'h0100, 5'b00000); check("R10 move16 high nonzero", 8'h00, 5'b00000);
    endtask

    task automatic t_hold();
        run_op(4'd5, 8'h12, 8'h00, 16'h0, 5'b00000); check("R2 load", 8'h12, 5'b00000);
        @(negedge clk);
        op = 4'd0; acc = 8'hFF; opnd = 8'hFF; flags_in = 5'b11111; en = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 hold", 8'h12, 5'b00000);
    endtask

    task automatic t_reserved();
        run_op(4'd14, 8'h5A, 8'h00, 16'h0, 5'b10110); check("R11 reserved 14", 8'h5A, 5'b10110);
        run_op(4'd15, 8'h00, 8'hFF, 16'h0, 5'b00001); check("R11 reserved 15", 8'h00, 5'b00001);
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_shift();
        t_daa();
        t_move();
        t_hold();
        t_reserved();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule